// File: doc/BRIEF.md
# Dual-Bank Masked Interrupt Aggregator

This block gathers single-cycle event pulses from hardware into two sticky status banks. One bank holds ordinary completion and notification events. The other holds error conditions. Each bank has a mask. A bit that is set in a status register and clear in the mask of the same bank makes the single level-sensitive interrupt output go high. Software reaches the banks through a small word-addressed 32-bit register bus.

Software clears status bits by writing ones to them. Software does not write a mask directly: one write-only strobe clears mask bits and a second write-only strobe sets them, so a read-modify-write is never needed. The event inputs are usually wired per channel. In the ordinary bank, bit n (n = 0..5) reports descriptor completion on channel n, bit 12+n reports a payload fetch failure on channel n, and bit 27 reports a frame-sync event. In the error bank, four bit groups start at 1, 7, 13 and 25, each with one bit per channel n. They report, in that order, a descriptor fetch failure, a bad preamble, a checksum mismatch and a descriptor that was already marked done.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset, both status registers read 0, the ordinary mask reads 0x07FFFFFF, the error mask reads 0xFFFFFFFF, and `irq_o` is low.
- R2: A one-cycle pulse on a bit of `norm_evt` or `err_evt` sets the matching status bit at the next clock edge. The bit stays set after the pulse ends.
- R3: A write to a status register (word 0 for the ordinary bank, word 4 for the error bank) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the unmask strobe (word 2 for the ordinary bank, word 6 for the error bank) clears each mask bit written as 1.
- R6: A write to the mask-set strobe (word 3 for the ordinary bank, word 7 for the error bank) sets each mask bit written as 1.
- R7: The mask registers (word 1 for the ordinary bank, word 5 for the error bank) can be read, and writes to them change nothing.
- R8: The four strobe words (2, 3, 6, 7) always read as 0.
- R9: `irq_o` is registered. It is high in the cycle after a cycle in which either bank has a status bit set with its mask bit clear, and low otherwise.
- R10: Words 8 and above read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| norm_evt | input | 32 | Event pulses for the ordinary bank |
| err_evt | input | 32 | Event pulses for the error bank |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse and a clearing write that land on the same status bit in the same cycle. The stimulus vector table drives the frame-sync event together with a write-one-to-clear of that same bit, then reads back the status word and `irq_o`. The masks reset to different values in the two banks, and bit 27 of the ordinary bank is unmasked straight out of reset. The table uses this to show that the interrupt is raised with no mask write at all. A directed sequence checks the one-cycle lag of `irq_o` on both its rising and its falling edge.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   // register select within a bank, taken from the two low word-address bits
   typedef enum logic [1:0] {
      RG_STAT    = 2'd0,
      RG_MASK    = 2'd1,
      RG_UNMASK  = 2'd2,
      RG_MASKSET = 2'd3
   } reg_sel_e;

   localparam int unsigned NUM_BANKS = 2;
   localparam int unsigned BANK_NORM = 0;
   localparam int unsigned BANK_ERR  = 1;
endpackage

// File: rtl/evt_irq_regdec.sv
module evt_irq_regdec
   import evt_irq_pkg::*;
#(
   parameter int unsigned AW = 4,
   parameter int unsigned NB = 2,
   localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   output logic          hit,
   output logic [BW-1:0] bank_idx,
   output reg_sel_e      rsel,
   output logic [NB-1:0] clr_we,
   output logic [NB-1:0] unmask_we,
   output logic [NB-1:0] maskset_we
);
   localparam int unsigned FIELD_W = 2 + BW;

   if (AW < FIELD_W) begin : g_bad_aw
      $error("evt_irq_regdec: AW too small for the bank map");
   end

   logic upper_zero;
   if (AW > FIELD_W) begin : g_upper
      assign upper_zero = ~|bus_addr[AW-1:FIELD_W];
   end else begin : g_no_upper
      assign upper_zero = 1'b1;
   end

   assign bank_idx = bus_addr[2 +: BW];
   assign rsel     = reg_sel_e'(bus_addr[1:0]);
   assign hit      = upper_zero && (int'(bank_idx) < int'(NB));

   for (genvar b = 0; b < NB; b++) begin : g_bank_we
      logic sel;
      assign sel           = bus_we && hit && (bank_idx == BW'(b));
      assign clr_we[b]     = sel && (rsel == RG_STAT);
      assign unmask_we[b]  = sel && (rsel == RG_UNMASK);
      assign maskset_we[b] = sel && (rsel == RG_MASKSET);
   end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
   parameter int unsigned DW = 32,
   parameter logic [DW-1:0] RST_MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] set_i,
   input  logic          clr_we,
   input  logic          unmask_we,
   input  logic          maskset_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] st_o,
   output logic [DW-1:0] mk_o,
   output logic          pend_o
);
   logic [DW-1:0] clr_bits;

   // a set pulse is applied after the clear, so it wins on the same bit
   assign clr_bits = clr_we ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_o <= '0;
         mk_o <= RST_MASK;
      end else begin
         st_o <= (st_o & ~clr_bits) | set_i;
         if (unmask_we) begin
            mk_o <= mk_o & ~wdata;
         end else if (maskset_we) begin
            mk_o <= mk_o | wdata;
         end
      end
   end

   assign pend_o = |(st_o & ~mk_o);
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
   parameter int unsigned NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] pend,
   output logic          irq_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |pend;
   end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
   import evt_irq_pkg::*;
#(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 4,
   parameter logic [DW-1:0] NORM_MASK_RST = DW'(32'h07FF_FFFF),
   parameter logic [DW-1:0] ERR_MASK_RST  = DW'(32'hFFFF_FFFF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [DW-1:0] norm_evt,
   input  logic [DW-1:0] err_evt,
   output logic          irq_o
);
   localparam int unsigned NB = NUM_BANKS;
   localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1;

   if (DW < 1) begin : g_bad_dw
      $error("evt_irq_agg: DW must be at least 1");
   end

   logic          hit;
   logic [BW-1:0] bank_idx;
   reg_sel_e      rsel;
   logic [NB-1:0] clr_we, unmask_we, maskset_we, pend;
   logic [DW-1:0] bank_st [NB];
   logic [DW-1:0] bank_mk [NB];
   logic [DW-1:0] bank_set [NB];

   assign bank_set[BANK_NORM] = norm_evt;
   assign bank_set[BANK_ERR]  = err_evt;

   evt_irq_regdec #(.AW(AW), .NB(NB)) u_dec (
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .hit        (hit),
      .bank_idx   (bank_idx),
      .rsel       (rsel),
      .clr_we     (clr_we),
      .unmask_we  (unmask_we),
      .maskset_we (maskset_we)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      localparam logic [DW-1:0] RSTV = (b == BANK_NORM) ? NORM_MASK_RST : ERR_MASK_RST;
      evt_irq_bank #(.DW(DW), .RST_MASK(RSTV)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_i      (bank_set[b]),
         .clr_we     (clr_we[b]),
         .unmask_we  (unmask_we[b]),
         .maskset_we (maskset_we[b]),
         .wdata      (bus_wdata),
         .st_o       (bank_st[b]),
         .mk_o       (bank_mk[b]),
         .pend_o     (pend[b])
      );
   end

   evt_irq_out #(.NB(NB)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .irq_o (irq_o)
   );

   // readback: strobes and unmapped words return zero
   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (rsel)
            RG_STAT: bus_rdata = bank_st[bank_idx];
            RG_MASK: bus_rdata = bank_mk[bank_idx];
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_rdata,
   input logic [DW-1:0] norm_evt,
   input logic [DW-1:0] err_evt,
   input logic          irq_o,
   input logic [DW-1:0] nst,
   input logic [DW-1:0] nmk,
   input logic [DW-1:0] est,
   input logic [DW-1:0] emk
);
   logic wr_nst, wr_est, wr_nstrobe, wr_estrobe, rd_strobe;
   assign wr_nst     = bus_we && (bus_addr == AW'(0));
   assign wr_est     = bus_we && (bus_addr == AW'(4));
   assign wr_nstrobe = bus_we && ((bus_addr == AW'(2)) || (bus_addr == AW'(3)));
   assign wr_estrobe = bus_we && ((bus_addr == AW'(6)) || (bus_addr == AW'(7)));
   assign rd_strobe  = (bus_addr == AW'(2)) || (bus_addr == AW'(3)) ||
                       (bus_addr == AW'(6)) || (bus_addr == AW'(7));

   p_norm_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      |norm_evt |=> ((nst & $past(norm_evt)) == $past(norm_evt)));
   p_err_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      |err_evt |=> ((est & $past(err_evt)) == $past(err_evt)));
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_nst && |norm_evt) |=> ((nst & $past(norm_evt)) == $past(norm_evt)));
   p_norm_clear_only_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_nst |=> ((nst & $past(nst)) == $past(nst)));
   p_err_clear_only_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_est |=> ((est & $past(est)) == $past(est)));
   p_norm_mask_by_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_nstrobe |=> $stable(nmk));
   p_err_mask_by_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_estrobe |=> $stable(emk));
   p_strobe_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |-> (bus_rdata == '0));
   p_irq_lags_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past((|(nst & ~nmk)) || (|(est & ~emk)))));
endmodule

bind evt_irq_agg evt_irq_agg_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .norm_evt  (norm_evt),
   .err_evt   (err_evt),
   .irq_o     (irq_o),
   .nst       (bank_st[0]),
   .nmk       (bank_mk[0]),
   .est       (bank_st[1]),
   .emk       (bank_mk[1])
);

// File: tb/tb_evt_irq_agg.sv
module tb_evt_irq_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] norm_evt = '0;
   logic [31:0] err_evt = '0;
   logic        irq_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   evt_irq_agg dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .norm_evt(norm_evt),
      .err_evt(err_evt), .irq_o(irq_o)
   );

   typedef struct packed {
      logic [23:0] tag;
      logic        we;
      logic [3:0]  addr;
      logic [31:0] wdata;
      logic [31:0] nev;
      logic [31:0] eev;
      logic [3:0]  caddr;
      logic [31:0] exp;
      logic        eirq;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VT [NV] = '{
      '{"R2 ", 1'b0, 4'h0, 32'h0,         32'h0000_0001, 32'h0,         4'h0, 32'h0000_0001, 1'b0},
      '{"R5 ", 1'b1, 4'h2, 32'h0000_0001, 32'h0,         32'h0,         4'h1, 32'h07FF_FFFE, 1'b1},
      '{"R6 ", 1'b1, 4'h3, 32'h0000_0001, 32'h0,         32'h0,         4'h1, 32'h07FF_FFFF, 1'b0},
      '{"R7 ", 1'b1, 4'h1, 32'h0,         32'h0,         32'h0,         4'h1, 32'h07FF_FFFF, 1'b0},
      '{"R3 ", 1'b1, 4'h0, 32'h0,         32'h0,         32'h0,         4'h0, 32'h0000_0001, 1'b0},
      '{"R3 ", 1'b1, 4'h0, 32'h0000_0001, 32'h0,         32'h0,         4'h0, 32'h0,         1'b0},
      '{"R2 ", 1'b0, 4'h0, 32'h0,         32'h0,         32'h0000_0080, 4'h4, 32'h0000_0080, 1'b0},
      '{"R5 ", 1'b1, 4'h6, 32'h0000_0080, 32'h0,         32'h0,         4'h5, 32'hFFFF_FF7F, 1'b1},
      '{"R3 ", 1'b1, 4'h4, 32'h0000_0080, 32'h0,         32'h0,         4'h4, 32'h0,         1'b0},
      '{"R7 ", 1'b1, 4'h5, 32'h0,         32'h0,         32'h0,         4'h5, 32'hFFFF_FF7F, 1'b0},
      '{"R6 ", 1'b1, 4'h7, 32'hFFFF_FFFF, 32'h0,         32'h0,         4'h5, 32'hFFFF_FFFF, 1'b0},
      '{"R9 ", 1'b0, 4'h0, 32'h0,         32'h0800_0000, 32'h0,         4'h0, 32'h0800_0000, 1'b1},
      '{"R4 ", 1'b1, 4'h0, 32'h0800_0000, 32'h0800_0000, 32'h0,         4'h0, 32'h0800_0000, 1'b1},
      '{"R3 ", 1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0,         32'h0,         4'h0, 32'h0,         1'b0},
      '{"R10", 1'b1, 4'hA, 32'hFFFF_FFFF, 32'h0,         32'h0,         4'h1, 32'h07FF_FFFF, 1'b0},
      '{"R10", 1'b0, 4'h0, 32'h0,         32'h0,         32'h0,         4'hA, 32'h0,         1'b0},
      '{"R8 ", 1'b0, 4'h0, 32'h0,         32'h0,         32'h0,         4'h2, 32'h0,         1'b0},
      '{"R8 ", 1'b0, 4'h0, 32'h0,         32'h0,         32'h0,         4'h7, 32'h0,         1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic idle();
      bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; norm_evt = '0; err_evt = '0;
   endtask

   task automatic reset_checks();
      rd_chk("R1 norm status", 4'h0, 32'h0);
      rd_chk("R1 norm mask",   4'h1, 32'h07FF_FFFF);
      rd_chk("R1 err status",  4'h4, 32'h0);
      rd_chk("R1 err mask",    4'h5, 32'hFFFF_FFFF);
      check("R1 irq", {31'b0, irq_o}, 32'h0);
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      reset_checks();

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         bus_we = VT[i].we; bus_addr = VT[i].addr; bus_wdata = VT[i].wdata;
         norm_evt = VT[i].nev; err_evt = VT[i].eev;
         @(negedge clk);
         idle();
         @(negedge clk);
         rd_chk($sformatf("%s vector %0d rdata", VT[i].tag, i), VT[i].caddr, VT[i].exp);
         check($sformatf("%s vector %0d irq", VT[i].tag, i), {31'b0, irq_o}, {31'b0, VT[i].eirq});
      end

      // R9: one-cycle lag of irq_o on the way up and down
      @(negedge clk);
      norm_evt = 32'h0800_0000;
      @(negedge clk);
      idle();
      check("R9 irq not yet high", {31'b0, irq_o}, 32'h0);
      rd_chk("R2 frame-sync status", 4'h0, 32'h0800_0000);
      @(negedge clk);
      check("R9 irq high one cycle later", {31'b0, irq_o}, 32'h1);
      bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0800_0000;
      @(negedge clk);
      idle();
      check("R9 irq still high after clear edge", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      check("R9 irq low one cycle after clear", {31'b0, irq_o}, 32'h0);

      // R1: reset restores everything after activity in both banks
      err_evt = 32'h0000_0002; bus_we = 1'b1; bus_addr = 4'h6; bus_wdata = 32'h0000_0002;
      @(negedge clk);
      idle();
      @(negedge clk);
      check("R9 error bank raises irq", {31'b0, irq_o}, 32'h1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      reset_checks();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog (all requirements) actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule